// File: doc/BRIEF.md
# Baud Clock Source Selector

This block produces the serial clock enables for one receiver and one transmitter. It runs on a single reference clock. From that clock it derives a ladder of twenty-two standard rates, each as a one-cycle enable pulse at sixteen times the baud rate. A 5-bit select code, held separately for the receiver and the transmitter, chooses one source for each direction. The source is either one of the generated rates, one of two general-purpose inputs, one of two counter/timer outputs, or a dedicated external pin clock. The pin clock can be taken in 16x or in 1x mode.

The divisors are fixed integers, so every generated rate follows the reference frequency in proportion. The nominal reference is 3.6864 MHz. At that frequency, code 0 gives 50 baud and code 21 gives 230.4K baud. Doubling the reference doubles every rate. External sources pass through a synchronizer and rising-edge detector, and each rising edge becomes one enable pulse. A flag beside each enable tells the shifter whether the chosen clock is a 1x clock.

Top module: `baud_src_sel`

## Requirements
- R1: Each select register stores csr_wdata (5 bits) when its write strobe is high at a clock edge. Its readback shows the code in bits 4:0 and ones in bits 7:5. Reset loads code 11111, so readback is 8'hFF.
- R2: Codes 0 to 15 select 50, 75, 150, 200, 300, 450, 600, 900, 1200, 1800, 2400, 3600, 4800, 7200, 9600 and 14400 baud. The enable is one cycle wide and repeats every 3686400/(16*baud) reference cycles, for example 4608 cycles for code 0 and 24 cycles for code 14.
- R3: Codes 16 to 21 select 19200, 28800, 38400, 57600, 115200 and 230400 baud, using the same divisor rule. Code 21 gives an enable on every cycle.
- R4: Code 22 passes general input 0 and code 23 passes general input 1. Each rising edge of the chosen input gives exactly one enable pulse after the synchronizer. The other input has no effect.
- R5: Code 24 passes counter/timer input 0 and code 25 passes counter/timer input 1. Each gives one pulse per rising edge, and the other input is ignored.
- R6: Code 27 passes the direction's own pin clock in 16x mode, and code 28 passes it in 1x mode. The receiver uses rx_ext_clk and the transmitter uses tx_ext_clk. The 1x flag is high only for code 28.
- R7: Reserved codes 26, 29, 30 and 31 give no enable pulse and a low 1x flag, whatever the external inputs do.
- R8: Every write to a select register restarts that direction's divider. With a rate code, the first pulse appears divisor cycles after the write edge, and later pulses are exactly divisor cycles apart, so no short or merged pulse is produced.
- R9: The receiver and transmitter selections are independent. Writing or running one direction never produces a pulse on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_csr_we | input | 1 | Write strobe for the receiver select register |
| tx_csr_we | input | 1 | Write strobe for the transmitter select register |
| csr_wdata | input | 5 | Select code to write |
| rx_csr_rdata | output | 8 | Receiver select readback, bits 7:5 read as one |
| tx_csr_rdata | output | 8 | Transmitter select readback, bits 7:5 read as one |
| gen_in | input | 2 | General-purpose clock inputs |
| ct_in | input | 2 | Counter/timer clock outputs fed in |
| rx_ext_clk | input | 1 | Receiver external pin clock |
| tx_ext_clk | input | 1 | Transmitter external pin clock |
| rx_clk_en | output | 1 | Receiver clock enable pulse |
| tx_clk_en | output | 1 | Transmitter clock enable pulse |
| rx_mode_1x | output | 1 | Receiver source is a 1x clock |
| tx_mode_1x | output | 1 | Transmitter source is a 1x clock |

## Verification
The assertions check several properties on every cycle. They check that the readback follows each write, that reserved codes stay silent with the 1x flag low, and that the 1x flag never rises except on code 28. They also check that the spacing between rate pulses always equals the divisor for the current code, counted from the last write, and that an external source never yields two enables in adjacent cycles. Only the bench scenarios can show that each code reaches the right rate or input. Those scenarios also show that the non-selected inputs have no effect and that the receiver and transmitter leave each other untouched.

// File: rtl/baud_src_pkg.sv
package baud_src_pkg;

   localparam int unsigned CODE_W  = 5;
   localparam int unsigned N_RATES = 22;
   localparam int unsigned N_GIN   = 2;
   localparam int unsigned N_CT    = 2;

   typedef logic [CODE_W-1:0] sel_code_t;

   localparam sel_code_t CODE_GIN0  = 5'b10110;
   localparam sel_code_t CODE_GIN1  = 5'b10111;
   localparam sel_code_t CODE_CT0   = 5'b11000;
   localparam sel_code_t CODE_CT1   = 5'b11001;
   localparam sel_code_t CODE_PIN16 = 5'b11011;
   localparam sel_code_t CODE_PIN1  = 5'b11100;
   localparam sel_code_t CODE_OFF   = 5'b11111;

   typedef enum logic [2:0] {
      SRC_RATE,
      SRC_GIN,
      SRC_CT,
      SRC_PIN,
      SRC_NONE
   } src_kind_t;

   // Baud value for each rate code, at the nominal reference.
   function automatic int unsigned baud_of(input int unsigned idx);
      case (idx)
         0:  return 50;
         1:  return 75;
         2:  return 150;
         3:  return 200;
         4:  return 300;
         5:  return 450;
         6:  return 600;
         7:  return 900;
         8:  return 1200;
         9:  return 1800;
         10: return 2400;
         11: return 3600;
         12: return 4800;
         13: return 7200;
         14: return 9600;
         15: return 14400;
         16: return 19200;
         17: return 28800;
         18: return 38400;
         19: return 57600;
         20: return 115200;
         21: return 230400;
         default: return 0;
      endcase
   endfunction

   // Reference cycles between 16x enables.
   function automatic int unsigned divisor_of(input int unsigned ref_hz,
                                              input int unsigned idx);
      if (baud_of(idx) == 0) return 1;
      return ref_hz / (16 * baud_of(idx));
   endfunction

   function automatic int unsigned max_divisor(input int unsigned ref_hz);
      return divisor_of(ref_hz, 0);
   endfunction

   function automatic src_kind_t kind_of(input sel_code_t c);
      if (c < sel_code_t'(N_RATES)) return SRC_RATE;
      case (c)
         CODE_GIN0, CODE_GIN1:  return SRC_GIN;
         CODE_CT0, CODE_CT1:    return SRC_CT;
         CODE_PIN16, CODE_PIN1: return SRC_PIN;
         default:               return SRC_NONE;
      endcase
   endfunction

endpackage

// File: rtl/baud_src_sync.sv
module baud_src_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("baud_src_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], din};
   end

   assign rise = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/baud_src_div.sv
module baud_src_div
   import baud_src_pkg::*;
#(
   parameter int unsigned REF_HZ = 3686400,
   parameter int unsigned CNT_W  = 13
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      restart,
   input  sel_code_t code,
   output logic      tick
);

   localparam int unsigned TAB_N = 2 ** CODE_W;

   logic [CNT_W-1:0] lim_tab [TAB_N];
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] cnt;
   logic             is_rate;

   for (genvar i = 0; i < TAB_N; i++) begin : g_tab
      if (i < N_RATES) begin : g_rate
         assign lim_tab[i] = CNT_W'(divisor_of(REF_HZ, i) - 1);
      end else begin : g_none
         assign lim_tab[i] = '0;
      end
   end

   assign is_rate = (code < sel_code_t'(N_RATES));
   assign limit   = lim_tab[code];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || !is_rate || (cnt == limit))
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign tick = is_rate && (cnt == limit);

endmodule

// File: rtl/baud_src_chan.sv
module baud_src_chan
   import baud_src_pkg::*;
#(
   parameter int unsigned REF_HZ      = 3686400,
   parameter int unsigned CNT_W       = 13,
   parameter int unsigned SYNC_STAGES = 2,
   parameter sel_code_t   RESET_CODE  = CODE_OFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_we,
   input  sel_code_t        sel_wdata,
   input  logic [N_GIN-1:0] gin_rise,
   input  logic [N_CT-1:0]  ct_rise,
   input  logic             pin_clk,
   output sel_code_t        sel_code,
   output logic             clk_en,
   output logic             mode_1x
);

   logic rate_tick;
   logic pin_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_code <= RESET_CODE;
      else if (sel_we) sel_code <= sel_wdata;
   end

   baud_src_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_clk),
      .rise (pin_rise)
   );

   baud_src_div #(.REF_HZ(REF_HZ), .CNT_W(CNT_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(sel_we),
      .code   (sel_code),
      .tick   (rate_tick)
   );

   always_comb begin
      case (kind_of(sel_code))
         SRC_RATE: clk_en = rate_tick;
         SRC_GIN:  clk_en = gin_rise[sel_code[0]];
         SRC_CT:   clk_en = ct_rise[sel_code[0]];
         SRC_PIN:  clk_en = pin_rise;
         default:  clk_en = 1'b0;
      endcase
   end

   assign mode_1x = (sel_code == CODE_PIN1);

endmodule

// File: rtl/baud_src_sel.sv
module baud_src_sel
   import baud_src_pkg::*;
#(
   parameter int unsigned REF_HZ      = 3686400,
   parameter int unsigned MAX_REF_HZ  = 8000000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter sel_code_t   RESET_CODE  = CODE_OFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_csr_we,
   input  logic              tx_csr_we,
   input  logic [CODE_W-1:0] csr_wdata,
   output logic [7:0]        rx_csr_rdata,
   output logic [7:0]        tx_csr_rdata,
   input  logic [N_GIN-1:0]  gen_in,
   input  logic [N_CT-1:0]   ct_in,
   input  logic              rx_ext_clk,
   input  logic              tx_ext_clk,
   output logic              rx_clk_en,
   output logic              tx_clk_en,
   output logic              rx_mode_1x,
   output logic              tx_mode_1x
);

   localparam int unsigned CNT_W  = $clog2(max_divisor(REF_HZ) + 1);
   localparam int unsigned N_CH   = 2;
   localparam int unsigned N_SHR  = N_GIN + N_CT;
   localparam int unsigned TOP_DIV = 16 * 230400;

   if (REF_HZ > MAX_REF_HZ) begin : g_bad_ref
      $error("baud_src_sel: REF_HZ above MAX_REF_HZ");
   end
   if ((REF_HZ % TOP_DIV) != 0) begin : g_bad_ratio
      $error("baud_src_sel: REF_HZ must be a multiple of 16*230400");
   end

   // Shared general and counter/timer inputs, synchronized once.
   logic [N_SHR-1:0] shr_raw;
   logic [N_SHR-1:0] shr_rise;

   assign shr_raw = {ct_in, gen_in};

   for (genvar s = 0; s < N_SHR; s++) begin : g_shr
      baud_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (shr_raw[s]),
         .rise (shr_rise[s])
      );
   end

   // Channel 0 is the receiver, channel 1 the transmitter.
   logic [N_CH-1:0] ch_we;
   logic [N_CH-1:0] ch_pin;
   logic [N_CH-1:0] ch_en;
   logic [N_CH-1:0] ch_m1x;
   sel_code_t       ch_code [N_CH];

   assign ch_we  = {tx_csr_we, rx_csr_we};
   assign ch_pin = {tx_ext_clk, rx_ext_clk};

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      baud_src_chan #(
         .REF_HZ     (REF_HZ),
         .CNT_W      (CNT_W),
         .SYNC_STAGES(SYNC_STAGES),
         .RESET_CODE (RESET_CODE)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel_we   (ch_we[c]),
         .sel_wdata(csr_wdata),
         .gin_rise (shr_rise[N_GIN-1:0]),
         .ct_rise  (shr_rise[N_SHR-1:N_GIN]),
         .pin_clk  (ch_pin[c]),
         .sel_code (ch_code[c]),
         .clk_en   (ch_en[c]),
         .mode_1x  (ch_m1x[c])
      );
   end

   assign rx_csr_rdata = {3'b111, ch_code[0]};
   assign tx_csr_rdata = {3'b111, ch_code[1]};
   assign rx_clk_en    = ch_en[0];
   assign tx_clk_en    = ch_en[1];
   assign rx_mode_1x   = ch_m1x[0];
   assign tx_mode_1x   = ch_m1x[1];

endmodule

// File: rtl/baud_src_sel_chk.sv
module baud_src_sel_chk
   import baud_src_pkg::*;
#(
   parameter int unsigned REF_HZ = 3686400
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_csr_we,
   input logic              tx_csr_we,
   input logic [CODE_W-1:0] csr_wdata,
   input logic [7:0]        rx_csr_rdata,
   input logic [7:0]        tx_csr_rdata,
   input logic              rx_clk_en,
   input logic              tx_clk_en,
   input logic              rx_mode_1x,
   input logic              tx_mode_1x
);

   sel_code_t   rx_code, tx_code;
   logic [31:0] rx_gap, tx_gap;

   assign rx_code = rx_csr_rdata[CODE_W-1:0];
   assign tx_code = tx_csr_rdata[CODE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rx_gap <= '0;
      else if (rx_csr_we || rx_clk_en)  rx_gap <= '0;
      else                              rx_gap <= rx_gap + 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       tx_gap <= '0;
      else if (tx_csr_we || tx_clk_en)  tx_gap <= '0;
      else                              tx_gap <= tx_gap + 1;
   end

   p_rx_rdwr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_csr_we |=> rx_csr_rdata == {3'b111, $past(csr_wdata)});
   p_tx_rdwr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_csr_we |=> tx_csr_rdata == {3'b111, $past(csr_wdata)});

   p_rx_rsvd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_of(rx_code) == SRC_NONE) |-> (!rx_clk_en && !rx_mode_1x));
   p_tx_rsvd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_of(tx_code) == SRC_NONE) |-> (!tx_clk_en && !tx_mode_1x));

   p_rx_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_mode_1x |-> (rx_code == CODE_PIN1));
   p_tx_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_mode_1x |-> (tx_code == CODE_PIN1));

   p_rx_rate_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_of(rx_code) == SRC_RATE && rx_clk_en) |->
         (rx_gap == divisor_of(REF_HZ, 32'(rx_code)) - 1));
   p_tx_rate_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_of(tx_code) == SRC_RATE && tx_clk_en) |->
         (tx_gap == divisor_of(REF_HZ, 32'(tx_code)) - 1));

   p_rx_ext_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_of(rx_code) inside {SRC_GIN, SRC_CT, SRC_PIN} && rx_clk_en && !rx_csr_we)
         |=> !rx_clk_en);
   p_tx_ext_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_of(tx_code) inside {SRC_GIN, SRC_CT, SRC_PIN} && tx_clk_en && !tx_csr_we)
         |=> !tx_clk_en);

endmodule

bind baud_src_sel baud_src_sel_chk #(.REF_HZ(REF_HZ)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_csr_we   (rx_csr_we),
   .tx_csr_we   (tx_csr_we),
   .csr_wdata   (csr_wdata),
   .rx_csr_rdata(rx_csr_rdata),
   .tx_csr_rdata(tx_csr_rdata),
   .rx_clk_en   (rx_clk_en),
   .tx_clk_en   (tx_clk_en),
   .rx_mode_1x  (rx_mode_1x),
   .tx_mode_1x  (tx_mode_1x)
);

// File: tb/baud_src_sel_tb.sv
`timescale 1ns/1ps
module baud_src_sel_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_csr_we = 1'b0;
   logic       tx_csr_we = 1'b0;
   logic [4:0] csr_wdata = '0;
   logic [7:0] rx_csr_rdata, tx_csr_rdata;
   logic [5:0] ext_drv = '0;   // [1:0] gen, [3:2] ct, [4] rx pin, [5] tx pin
   logic       rx_clk_en, tx_clk_en, rx_mode_1x, tx_mode_1x;

   int checks = 0;
   int errors = 0;
   int rx_seen = 0;
   int tx_seen = 0;

   always #2.5 clk = ~clk;

   baud_src_sel u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_csr_we   (rx_csr_we),
      .tx_csr_we   (tx_csr_we),
      .csr_wdata   (csr_wdata),
      .rx_csr_rdata(rx_csr_rdata),
      .tx_csr_rdata(tx_csr_rdata),
      .gen_in      (ext_drv[1:0]),
      .ct_in       (ext_drv[3:2]),
      .rx_ext_clk  (ext_drv[4]),
      .tx_ext_clk  (ext_drv[5]),
      .rx_clk_en   (rx_clk_en),
      .tx_clk_en   (tx_clk_en),
      .rx_mode_1x  (rx_mode_1x),
      .tx_mode_1x  (tx_mode_1x)
   );

   function automatic int exp_baud(input int idx);
      case (idx)
         0: return 50;      1: return 75;      2: return 150;     3: return 200;
         4: return 300;     5: return 450;     6: return 600;     7: return 900;
         8: return 1200;    9: return 1800;    10: return 2400;   11: return 3600;
         12: return 4800;   13: return 7200;   14: return 9600;   15: return 14400;
         16: return 19200;  17: return 28800;  18: return 38400;  19: return 57600;
         20: return 115200; 21: return 230400;
         default: return 1;
      endcase
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      if (rx_clk_en) rx_seen++;
      if (tx_clk_en) tx_seen++;
   endtask

   // Returns at the first negedge after the write edge.
   task automatic wr(input bit tx, input logic [4:0] code);
      step();
      csr_wdata = code;
      rx_csr_we = !tx;
      tx_csr_we = tx;
      step();
      rx_csr_we = 1'b0;
      tx_csr_we = 1'b0;
   endtask

   task automatic measure(input bit tx, input int div, input string req);
      int first;
      int base;
      logic en;
      first = 0;
      for (int n = 1; n <= div && first == 0; n++) begin
         if (n > 1) step();
         en = tx ? tx_clk_en : rx_clk_en;
         if (en) first = n;
      end
      check(req, "first pulse cycle", first, div);
      base = tx ? tx_seen : rx_seen;
      repeat (3 * div) step();
      check(req, "pulses in 3 periods", (tx ? tx_seen : rx_seen) - base, 3);
   endtask

   task automatic run_rate(input bit tx, input int idx);
      wr(tx, 5'(idx));
      measure(tx, 3686400 / (16 * exp_baud(idx)), idx < 16 ? "R2" : "R3");
   endtask

   task automatic pulse(input logic [5:0] mask, input int times);
      for (int i = 0; i < times; i++) begin
         ext_drv = mask;
         repeat (3) step();
         ext_drv = '0;
         repeat (3) step();
      end
      repeat (4) step();
   endtask

   task automatic test_reset();
      check("R1", "rx readback after reset", rx_csr_rdata, 8'hFF);
      check("R1", "tx readback after reset", tx_csr_rdata, 8'hFF);
      check("R7", "enables and flags after reset",
            {rx_clk_en, tx_clk_en, rx_mode_1x, tx_mode_1x}, 0);
   endtask

   task automatic test_readback();
      wr(0, 5'b00011);
      check("R1", "rx readback code 3", rx_csr_rdata, 8'hE3);
      check("R1", "tx unchanged", tx_csr_rdata, 8'hFF);
      wr(1, 5'b11010);
      check("R1", "tx readback code 26", tx_csr_rdata, 8'hFA);
      wr(0, 5'b11111);
   endtask

   task automatic test_rx_ladder();
      int t0;
      wr(1, 5'b11111);
      t0 = tx_seen;
      for (int idx = 0; idx < 22; idx++) run_rate(0, idx);
      check("R9", "tx pulses during rx ladder", tx_seen - t0, 0);
   endtask

   task automatic test_tx_rates();
      int r0;
      wr(0, 5'b11111);
      r0 = rx_seen;
      run_rate(1, 21);
      run_rate(1, 14);
      run_rate(1, 10);
      check("R9", "rx pulses during tx rates", rx_seen - r0, 0);
   endtask

   task automatic test_ext(input bit tx, input logic [4:0] code, input logic [5:0] sel_mask,
                           input logic [5:0] other_mask, input string req);
      int b;
      wr(tx, code);
      b = tx ? tx_seen : rx_seen;
      pulse(sel_mask, 5);
      check(req, "pulses from chosen input", (tx ? tx_seen : rx_seen) - b, 5);
      b = tx ? tx_seen : rx_seen;
      pulse(other_mask, 4);
      check(req, "pulses from other input", (tx ? tx_seen : rx_seen) - b, 0);
   endtask

   task automatic test_pins();
      test_ext(0, 5'b11011, 6'b010000, 6'b100000, "R6");
      check("R6", "rx 1x flag in 16x pin mode", rx_mode_1x, 0);
      test_ext(0, 5'b11100, 6'b010000, 6'b100000, "R6");
      check("R6", "rx 1x flag in 1x pin mode", rx_mode_1x, 1);
      test_ext(1, 5'b11100, 6'b100000, 6'b010000, "R6");
      check("R6", "tx 1x flag in 1x pin mode", tx_mode_1x, 1);
      check("R6", "rx flag untouched by tx", rx_mode_1x, 1);
   endtask

   task automatic test_reserved();
      int r0;
      int t0;
      logic [4:0] rsv [4] = '{5'b11010, 5'b11101, 5'b11110, 5'b11111};
      for (int k = 0; k < 4; k++) begin
         wr(0, rsv[k]);
         wr(1, rsv[k]);
         check("R7", "1x flags on reserved code", {rx_mode_1x, tx_mode_1x}, 0);
         r0 = rx_seen;
         t0 = tx_seen;
         pulse(6'h3F, 3);
         check("R7", "pulses on reserved code", (rx_seen - r0) + (tx_seen - t0), 0);
      end
   endtask

   task automatic test_restart();
      int r0;
      wr(0, 5'd14);
      r0 = rx_seen;
      repeat (10) step();
      check("R8", "no pulse before divisor", rx_seen - r0, 0);
      wr(0, 5'd14);
      measure(0, 24, "R8");
      wr(0, 5'd0);
      repeat (100) step();
      wr(0, 5'd21);
      measure(0, 1, "R8");
      wr(0, 5'd21);
      wr(0, 5'd19);
      measure(0, 4, "R8");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_readback();
      test_rx_ladder();
      test_tx_rates();
      test_ext(0, 5'b10110, 6'b000001, 6'b000010, "R4");
      test_ext(1, 5'b10111, 6'b000010, 6'b000001, "R4");
      test_ext(0, 5'b11000, 6'b000100, 6'b001000, "R5");
      test_ext(1, 5'b11001, 6'b001000, 6'b000100, "R5");
      test_pins();
      test_reserved();
      test_restart();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all requirements actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule